// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block provides cross-port signalling for a two-port RAM. The two highest word addresses serve as mailboxes. The address one below the top belongs to the left port, and the top address belongs to the right port. When one port writes the other port's mailbox, an interrupt flag is raised toward the owner of that mailbox. The owner lowers the flag by reading its own mailbox. The mailbox bytes themselves stay in the RAM as ordinary data. This block handles only the flags.

Each port presents its enable, output enable, write select, address and busy indication. The busy indications come from an arbiter outside this block. While a port is busy, any set or clear it would cause is suppressed. Both flags are registered. They change on the clock edge that samples the triggering access, and a synchronous reset lowers them.

Top module: `mbx_irq_flags`

## Requirements
- R1: While `rst` is high at a clock edge, both `l_irq` and `r_irq` are 0 after that edge.
- R2: A right-port write (`r_en`=1, `r_wr`=1, `r_busy`=0) to address 2^ADDR_W-2 (0x3FE by default) makes `l_irq` 1 after the edge.
- R3: A left-port write (`l_en`=1, `l_wr`=1, `l_busy`=0) to address 2^ADDR_W-1 (0x3FF by default) makes `r_irq` 1 after the edge.
- R4: A left access with `l_en`=1 and `l_oe`=1 at 0x3FE, with `l_busy`=0, clears `l_irq` after the edge, whatever the value of `l_wr`.
- R5: A right access with `r_en`=1 and `r_oe`=1 at 0x3FF, with `r_busy`=0, clears `r_irq` after the edge.
- R6: When the port that would set or clear a flag has its busy input at 1, that flag keeps its value.
- R7: If a flag is set and cleared in the same cycle, the flag ends up set.
- R8: A flag holds its value in all other cases. These cases include repeated writes to a mailbox whose flag is already set, accesses to other addresses, reads of the other port's mailbox, and output enable with the port enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_en | input | 1 | Left port enable |
| l_oe | input | 1 | Left port output enable |
| l_wr | input | 1 | Left port write select (1 = write) |
| l_addr | input | ADDR_W | Left port address |
| l_busy | input | 1 | Left port busy from the arbiter |
| r_en | input | 1 | Right port enable |
| r_oe | input | 1 | Right port output enable |
| r_wr | input | 1 | Right port write select (1 = write) |
| r_addr | input | ADDR_W | Right port address |
| r_busy | input | 1 | Right port busy from the arbiter |
| l_irq | output | 1 | Interrupt toward the left port |
| r_irq | output | 1 | Interrupt toward the right port |

## Verification
The hardest case to reach is a set and a clear of the same flag landing in the same cycle, with the two ports' busy states mixed. This case only occurs when both ports target the same mailbox in a single cycle, one writing and one reading. The stimulus table places such rows directly after states in which the flag is both 0 and 1. It also adds rows where only the acting port is busy, so that each suppression path is observed at the output flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef struct packed {
        logic flag;
    } flag_state_t;

    // side 0 = left mailbox (top-1), side 1 = right mailbox (top)
    function automatic int unsigned box_addr(input int unsigned addr_w, input int unsigned side);
        return ((32'd1 << addr_w) - 32'd2) + side;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned OWN_BOX  = 1022,
    parameter int unsigned PEER_BOX = 1023
) (
    input  logic              en,
    input  logic              oe,
    input  logic              wr,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    output logic              post,
    output logic              take
);
    localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BOX);
    localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BOX);

    always_comb begin
        post = en && wr && !busy && (addr == PEER_A);
        take = en && oe && !busy && (addr == OWN_A);
    end
endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set)
            st_d.flag = 1'b1;
        else if (clr)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R7: set wins over a simultaneous clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);
    // R8: no request, no change
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_en,
    input  logic              l_oe,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy,
    input  logic              r_en,
    input  logic              r_oe,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy,
    output logic              l_irq,
    output logic              r_irq
);
    localparam int unsigned NPORT = 2;
    localparam logic [ADDR_W-1:0] L_BOX = ADDR_W'(box_addr(ADDR_W, 0));
    localparam logic [ADDR_W-1:0] R_BOX = ADDR_W'(box_addr(ADDR_W, 1));

    logic              p_en   [NPORT];
    logic              p_oe   [NPORT];
    logic              p_wr   [NPORT];
    logic              p_busy [NPORT];
    logic [ADDR_W-1:0] p_addr [NPORT];
    logic              p_post [NPORT];
    logic              p_take [NPORT];
    logic              p_irq  [NPORT];

    always_comb begin
        p_en[0] = l_en;   p_en[1] = r_en;
        p_oe[0] = l_oe;   p_oe[1] = r_oe;
        p_wr[0] = l_wr;   p_wr[1] = r_wr;
        p_busy[0] = l_busy; p_busy[1] = r_busy;
        p_addr[0] = l_addr; p_addr[1] = r_addr;
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        mbx_port_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX (box_addr(ADDR_W, i)),
            .PEER_BOX(box_addr(ADDR_W, NPORT - 1 - i))
        ) i_dec (
            .en  (p_en[i]),
            .oe  (p_oe[i]),
            .wr  (p_wr[i]),
            .busy(p_busy[i]),
            .addr(p_addr[i]),
            .post(p_post[i]),
            .take(p_take[i])
        );

        mbx_flag_cell i_flag (
            .clk (clk),
            .rst (rst),
            .set (p_post[NPORT - 1 - i]),
            .clr (p_take[i]),
            .flag(p_irq[i])
        );
    end

    assign l_irq = p_irq[0];
    assign r_irq = p_irq[1];

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!l_irq && !r_irq));
    p_right_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (r_en && r_wr && !r_busy && r_addr == L_BOX) |=> l_irq);
    p_left_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (l_en && l_wr && !l_busy && l_addr == R_BOX) |=> r_irq);
    p_right_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (r_en && r_oe && !r_busy && r_addr == R_BOX
         && !(l_en && l_wr && !l_busy && l_addr == R_BOX)) |=> !r_irq);
    // R6: a busy owner cannot lower its flag; a busy sender cannot raise it
    p_busy_keep_l_r6: assert property (@(posedge clk) disable iff (rst)
        (l_busy && l_irq) |=> l_irq);
    p_busy_keep_r_r6: assert property (@(posedge clk) disable iff (rst)
        (r_busy && r_irq) |=> r_irq);
    p_busy_noset_l_r6: assert property (@(posedge clk) disable iff (rst)
        (r_busy && !l_irq) |=> !l_irq);
endmodule

// File: tb/test_mbx_irq_flags.sv
module test_mbx_irq_flags;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam logic [AW-1:0] LB = 10'h3FE;
    localparam logic [AW-1:0] RB = 10'h3FF;

    typedef struct packed {
        logic [3:0]    req;
        logic          le, lo, lw, lb;
        logic [AW-1:0] la;
        logic          re, ro, rw, rb;
        logic [AW-1:0] ra;
        logic          xl, xr;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{4'd8, 1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b0,1'b0}, // R8 idle
        '{4'd2, 1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b1,1'b0,1'b1,1'b0, LB,      1'b1,1'b0}, // R2 set left
        '{4'd8, 1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b1,1'b0,1'b1,1'b0, LB,      1'b1,1'b0}, // R8 rewrite
        '{4'd4, 1'b1,1'b1,1'b1,1'b0, LB,      1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b0,1'b0}, // R4 clear, wr ignored
        '{4'd3, 1'b1,1'b0,1'b1,1'b0, RB,      1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b0,1'b1}, // R3 set right
        '{4'd6, 1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b1,1'b1,1'b0,1'b1, RB,      1'b0,1'b1}, // R6 busy clear
        '{4'd5, 1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b1,1'b1,1'b0,1'b0, RB,      1'b0,1'b0}, // R5 clear right
        '{4'd6, 1'b1,1'b0,1'b1,1'b1, RB,      1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b0,1'b0}, // R6 busy set
        '{4'd8, 1'b1,1'b0,1'b1,1'b0, 10'h3FD, 1'b1,1'b1,1'b0,1'b0, LB,      1'b0,1'b0}, // R8 other addr
        '{4'd2, 1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b1,1'b0,1'b1,1'b0, LB,      1'b1,1'b0}, // R2 set again
        '{4'd8, 1'b0,1'b1,1'b0,1'b0, LB,      1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b1,1'b0}, // R8 oe w/o en
        '{4'd7, 1'b1,1'b1,1'b0,1'b0, LB,      1'b1,1'b0,1'b1,1'b0, LB,      1'b1,1'b0}, // R7 set beats clear
        '{4'd6, 1'b1,1'b1,1'b0,1'b1, LB,      1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b1,1'b0}, // R6 busy owner
        '{4'd4, 1'b1,1'b1,1'b0,1'b0, LB,      1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b0,1'b0}, // R4 clear
        '{4'd7, 1'b1,1'b0,1'b1,1'b0, RB,      1'b1,1'b1,1'b0,1'b0, RB,      1'b0,1'b1}, // R7 right side
        '{4'd6, 1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b1,1'b0,1'b1,1'b1, LB,      1'b0,1'b1}  // R6 busy sender
    };

    logic clk = 1'b0;
    logic rst;
    logic l_en, l_oe, l_wr, l_busy, r_en, r_oe, r_wr, r_busy;
    logic [AW-1:0] l_addr, r_addr;
    logic l_irq, r_irq;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq_flags #(.ADDR_W(AW)) i_mbx_irq_flags (
        .clk(clk), .rst(rst),
        .l_en(l_en), .l_oe(l_oe), .l_wr(l_wr), .l_addr(l_addr), .l_busy(l_busy),
        .r_en(r_en), .r_oe(r_oe), .r_wr(r_wr), .r_addr(r_addr), .r_busy(r_busy),
        .l_irq(l_irq), .r_irq(r_irq)
    );

    task automatic check(input int req, input logic al, input logic ar,
                         input logic el, input logic er);
        total++;
        if (al !== el || ar !== er) begin
            bad++;
            $display("FAIL R%0d: l_irq=%b r_irq=%b expected l_irq=%b r_irq=%b",
                     req, al, ar, el, er);
        end
    endtask

    task automatic apply(input vec_t v);
        l_en = v.le; l_oe = v.lo; l_wr = v.lw; l_busy = v.lb; l_addr = v.la;
        r_en = v.re; r_oe = v.ro; r_wr = v.rw; r_busy = v.rb; r_addr = v.ra;
    endtask

    initial begin
        apply('0);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(1, l_irq, r_irq, 1'b0, 1'b0); // R1 reset state
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            @(posedge clk);
            #(CLK_PERIOD/4);
            check(int'(TBL[i].req), l_irq, r_irq, TBL[i].xl, TBL[i].xr);
            @(negedge clk);
        end
        // R1: reset mid-run while r_irq is set and a set request is present
        apply('{4'd1, 1'b0,1'b0,1'b0,1'b0, 10'h000, 1'b1,1'b0,1'b1,1'b0, LB, 1'b0,1'b0});
        rst = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(1, l_irq, r_irq, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        apply('0);
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(8, l_irq, r_irq, 1'b0, 1'b0); // R8 idle after reset
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule